// File: doc/BRIEF.md
# Two-Wire Serial Slave with Mode Register

This block is the host-facing side of a data-acquisition unit. It answers a standard I2C master on a pair of open-drain lines. It holds one 8-bit control register that picks the acquisition mode, and it returns a block of captured bytes to the host. The bus lines are oversampled by a fast system clock through synchronisers, and the block detects edges, START and STOP from the synchronised copies. The block only pulls SDA low and never drives it high. Its output `sda_pull` is meant for an open-drain pad.

A write transaction is a single control byte: START, the write address, an acknowledge from the slave, the byte, an acknowledge, then STOP. There is no sub-address. A read transaction streams the captured bytes, starting at byte 1 every time. The slave keeps sending while the master acknowledges and stops at the first missing acknowledge. One input pin chooses between two address pairs, so two of these blocks can share one bus.

While the block is addressed, the `bus_busy` output is high. The acquisition logic uses it to hold the captured bytes steady during the transfer.

Top module: `ctl_twowire_slave`

## Requirements
- R1: With `cs_sel` low the block acknowledges 8-bit address bytes 0x20 (write) and 0x21 (read). With `cs_sel` high it acknowledges 0x22 and 0x23. Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R2: In a write, the single data byte is acknowledged and stored whole in `ctrl_reg`. The fields are: bit 0 selects format 2 data (0) or format 1/header data (1); bit 1 selects dedicated-line mode (0) or packet mode (1); bit 2 selects format 1 data (0) or header row (1); bit 3 selects header order A (0) or B (1); bits 7:4 are test bits.
- R3: After reset, `ctrl_reg` is 0x00, `bus_busy` is 0 and SDA is released.
- R4: Read byte k (k = 1..NUM_BYTES) is `xfer_bytes[8k-1:8k-8]`, sent most significant bit first.
- R5: A master acknowledge moves to the next byte. A master non-acknowledge ends the read, and SDA is released from then on.
- R6: Every START, including a repeated START with no STOP before it, makes the next read begin again at byte 1.
- R7: Reads beyond byte NUM_BYTES return 0xFF, and the byte counter stays at its limit.
- R8: `bus_busy` rises when an address matches and stays high until the next STOP or START. A mismatched address does not raise it.
- R9: The slave changes its SDA pull only while the synchronised SCL is low, except that a STOP releases it. The data it sends stays constant while SCL is high.
- R10: A second data byte in a write transaction is not acknowledged and does not change `ctrl_reg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_sel | input | 1 | Chooses the address pair: 0 for 0x20/0x21, 1 for 0x22/0x23 |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| xfer_bytes | input | NUM_BYTES*8 | Captured bytes; byte k is at bits 8k-1:8k-8 |
| ctrl_reg | output | 8 | Mode control register |
| bus_busy | output | 1 | High while the block is addressed |

## Verification
The assertions assume the master obeys the line rules: SDA moves only while SCL is low, except at START and STOP, and each SCL phase lasts longer than the synchroniser delay. Under those rules a synchronised START or STOP is never confused with a data bit, and the slave's own pull changes only after it has seen SCL fall. The bench master holds every SCL quarter-phase for several system clocks and changes SDA only in the low phase. It releases SDA whenever the slave is expected to drive, so the wired-AND line shows exactly what the slave sends.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      TWS_IDLE,
      TWS_ADDR,
      TWS_AACK,
      TWS_WBYTE,
      TWS_WACK,
      TWS_RBYTE,
      TWS_RACK
   } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/tws_line_events.sv
module tws_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tws_byte_sel.sv
module tws_byte_sel #(
   parameter int NUM_BYTES = 16,
   parameter int PTR_W     = 5
) (
   input  logic [NUM_BYTES*8-1:0] bytes,
   input  logic [PTR_W-1:0]       idx,
   output logic [7:0]             q
);
   always_comb begin
      q = 8'hFF;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (idx == PTR_W'(i)) q = bytes[i*8 +: 8];
      end
   end
endmodule

// File: rtl/tws_engine.sv
module tws_engine
   import tws_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE = 7'h10,
   parameter int         NUM_BYTES = 16,
   parameter int         PTR_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_sel,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_byte,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             sda_pull,
   output logic [7:0]       ctrl_reg,
   output logic             bus_busy
);
   localparam logic [PTR_W-1:0] PTR_LIMIT = PTR_W'(NUM_BYTES);

   tws_state_e state;
   logic [7:0] sreg;
   logic [3:0] bitcnt;
   logic       is_read;
   logic       master_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= TWS_IDLE;
         sreg       <= '0;
         bitcnt     <= '0;
         is_read    <= 1'b0;
         master_ack <= 1'b0;
         rd_ptr     <= '0;
         sda_pull   <= 1'b0;
         ctrl_reg   <= '0;
         bus_busy   <= 1'b0;
      end else if (start_det) begin
         state    <= TWS_ADDR;
         bitcnt   <= '0;
         rd_ptr   <= '0;
         bus_busy <= 1'b0;
         sda_pull <= 1'b0;
      end else if (stop_det) begin
         state    <= TWS_IDLE;
         bus_busy <= 1'b0;
         sda_pull <= 1'b0;
      end else begin
         unique case (state)
            TWS_ADDR: begin
               if (scl_rise) begin
                  sreg   <= {sreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  if (sreg[7:1] == (ADDR_BASE | {6'd0, cs_sel})) begin
                     sda_pull <= 1'b1;
                     is_read  <= sreg[0];
                     bus_busy <= 1'b1;
                     state    <= TWS_AACK;
                  end else begin
                     state <= TWS_IDLE;
                  end
               end
            end
            TWS_AACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (is_read) begin
                     sreg     <= rd_byte;
                     sda_pull <= ~rd_byte[7];
                     state    <= TWS_RBYTE;
                  end else begin
                     sda_pull <= 1'b0;
                     state    <= TWS_WBYTE;
                  end
               end
            end
            TWS_WBYTE: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  sreg   <= {sreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  sda_pull <= 1'b1;
                  ctrl_reg <= sreg;
                  state    <= TWS_WACK;
               end
            end
            TWS_WACK: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  state    <= TWS_IDLE;
               end
            end
            TWS_RBYTE: begin
               if (scl_fall) begin
                  bitcnt <= bitcnt + 4'd1;
                  if (bitcnt == 4'd7) begin
                     sda_pull <= 1'b0;
                     state    <= TWS_RACK;
                  end else begin
                     sreg     <= {sreg[6:0], 1'b0};
                     sda_pull <= ~sreg[6];
                  end
               end
            end
            TWS_RACK: begin
               if (scl_rise) begin
                  master_ack <= ~sda_s;
                  if (!sda_s && rd_ptr != PTR_LIMIT) rd_ptr <= rd_ptr + 1'b1;
               end else if (scl_fall) begin
                  if (master_ack) begin
                     bitcnt   <= '0;
                     sreg     <= rd_byte;
                     sda_pull <= ~rd_byte[7];
                     state    <= TWS_RBYTE;
                  end else begin
                     state <= TWS_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ctl_twowire_slave.sv
module ctl_twowire_slave #(
   parameter logic [6:0] ADDR_BASE   = 7'h10,
   parameter int         NUM_BYTES   = 16,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_sel,
   input  logic                   scl_in,
   input  logic                   sda_in,
   output logic                   sda_pull,
   input  logic [NUM_BYTES*8-1:0] xfer_bytes,
   output logic [7:0]             ctrl_reg,
   output logic                   bus_busy
);
   localparam int PTR_W = $clog2(NUM_BYTES + 1);

   if (NUM_BYTES < 1 || NUM_BYTES > 255) begin : g_bad_depth
      $error("NUM_BYTES must lie in 1..255");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_BASE[0] != 1'b0) begin : g_bad_addr
      $error("ADDR_BASE bit 0 is reserved for cs_sel");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic [PTR_W-1:0] rd_ptr;
   logic [7:0]       rd_byte;

   tws_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   tws_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   tws_line_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   tws_byte_sel #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_sel (
      .bytes(xfer_bytes), .idx(rd_ptr), .q(rd_byte));

   tws_engine #(.ADDR_BASE(ADDR_BASE), .NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .rd_byte(rd_byte), .rd_ptr(rd_ptr), .sda_pull(sda_pull),
      .ctrl_reg(ctrl_reg), .bus_busy(bus_busy));
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
   parameter int NUM_BYTES = 16,
   parameter int PTR_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_det,
   input logic             stop_det,
   input logic             sda_pull,
   input logic             bus_busy,
   input logic [7:0]       ctrl_reg,
   input logic [PTR_W-1:0] rd_ptr
);
   assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr <= PTR_W'(NUM_BYTES));

   assert_start_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (rd_ptr == '0));

   assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull);

   assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_pull) && !$past(stop_det) && !$past(start_det)) |-> !$past(scl_s));

   assert_cond_clears_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !bus_busy);

   assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_busy) |-> $past(start_det || stop_det));

   assert_ctrl_in_txn_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_reg) |-> $past(bus_busy));
endmodule

bind ctl_twowire_slave tws_checker #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_pull(sda_pull), .bus_busy(bus_busy),
   .ctrl_reg(ctrl_reg), .rd_ptr(rd_ptr));

// File: tb/ctl_twowire_slave_tb.sv
module ctl_twowire_slave_tb;
   localparam int NB = 16;
   localparam int Q  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_sel = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_pull;
   logic sda_line;
   logic [NB*8-1:0] xfer_bytes;
   logic [7:0] ctrl_reg;
   logic bus_busy;
   int nvec = 0;
   int nbad = 0;
   bit done = 0;
   int glitches = 0;

   always #10 clk = ~clk;

   assign sda_line = m_sda & ~sda_pull;

   ctl_twowire_slave u_dut (
      .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .scl_in(scl), .sda_in(sda_line),
      .sda_pull(sda_pull), .xfer_bytes(xfer_bytes), .ctrl_reg(ctrl_reg),
      .bus_busy(bus_busy));

   function automatic logic [7:0] bval(int k);
      return 8'((k * 37 + 3) & 255);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic q_wait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; q_wait();
      scl = 1'b1;   q_wait();
      m_sda = 1'b0; q_wait();
      scl = 1'b0;   q_wait();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; q_wait();
      scl = 1'b1;   q_wait();
      m_sda = 1'b1; q_wait();
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; q_wait();
      scl = 1'b1; q_wait(); q_wait();
      scl = 1'b0; q_wait();
   endtask

   task automatic get_bit(output logic b);
      logic early;
      m_sda = 1'b1; q_wait();
      scl = 1'b1;
      @(negedge clk); early = sda_line;
      repeat (Q - 1) @(negedge clk);
      b = sda_line;
      q_wait();
      if (sda_line !== early) glitches++;
      scl = 1'b0; q_wait();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~ack);
   endtask

   task automatic t_reset();
      chk("R3 ctrl_reg", 32'(ctrl_reg), 32'h00);
      chk("R3 bus_busy", 32'(bus_busy), 32'h0);
      chk("R3 sda_pull", 32'(sda_pull), 32'h0);
   endtask

   task automatic t_write();
      logic ack;
      bus_start();
      send_byte(8'h20, ack);
      chk("R1 write addr ack", 32'(ack), 32'h1);
      chk("R8 busy after match", 32'(bus_busy), 32'h1);
      send_byte(8'h0B, ack);
      chk("R2 data ack", 32'(ack), 32'h1);
      chk("R2 ctrl_reg value", 32'(ctrl_reg), 32'h0B);
      bus_stop();
      q_wait();
      chk("R8 busy after stop", 32'(bus_busy), 32'h0);
   endtask

   task automatic t_read(input int n);
      logic ack;
      logic [7:0] v;
      glitches = 0;
      bus_start();
      send_byte(8'h21, ack);
      chk("R1 read addr ack", 32'(ack), 32'h1);
      for (int k = 1; k <= n; k++) begin
         recv_byte(v, k != n);
         chk((k <= NB) ? "R4 R5 read byte" : "R7 past end", 32'(v),
             (k <= NB) ? 32'(bval(k)) : 32'hFF);
      end
      chk("R5 released after nack", 32'(sda_pull), 32'h0);
      chk("R9 stable while scl high", 32'(glitches), 32'h0);
      bus_stop();
   endtask

   task automatic t_restart();
      logic ack;
      logic [7:0] v;
      bus_start();
      send_byte(8'h21, ack);
      recv_byte(v, 1'b1);
      recv_byte(v, 1'b1);
      recv_byte(v, 1'b0);
      chk("R5 third byte", 32'(v), 32'(bval(3)));
      bus_start();
      send_byte(8'h21, ack);
      chk("R6 restart ack", 32'(ack), 32'h1);
      recv_byte(v, 1'b0);
      chk("R6 rewound to byte 1", 32'(v), 32'(bval(1)));
      bus_stop();
   endtask

   task automatic t_mismatch();
      logic ack;
      bus_start();
      send_byte(8'h22, ack);
      chk("R1 foreign addr no ack", 32'(ack), 32'h0);
      chk("R8 busy stays low", 32'(bus_busy), 32'h0);
      send_byte(8'h55, ack);
      chk("R1 ignored byte no ack", 32'(ack), 32'h0);
      bus_stop();
      chk("R1 ctrl untouched", 32'(ctrl_reg), 32'h0B);
   endtask

   task automatic t_cs_high();
      logic ack;
      logic [7:0] v;
      cs_sel = 1'b1;
      bus_start();
      send_byte(8'h20, ack);
      chk("R1 cs high rejects 0x20", 32'(ack), 32'h0);
      bus_stop();
      bus_start();
      send_byte(8'h22, ack);
      chk("R1 cs high accepts 0x22", 32'(ack), 32'h1);
      send_byte(8'hF4, ack);
      bus_stop();
      chk("R2 ctrl test bits", 32'(ctrl_reg), 32'hF4);
      bus_start();
      send_byte(8'h23, ack);
      chk("R1 cs high accepts 0x23", 32'(ack), 32'h1);
      recv_byte(v, 1'b0);
      chk("R4 cs high byte 1", 32'(v), 32'(bval(1)));
      bus_stop();
      cs_sel = 1'b0;
   endtask

   task automatic t_extra_write();
      logic ack;
      bus_start();
      send_byte(8'h20, ack);
      send_byte(8'h03, ack);
      chk("R2 first byte ack", 32'(ack), 32'h1);
      send_byte(8'h99, ack);
      chk("R10 second byte no ack", 32'(ack), 32'h0);
      chk("R10 busy until stop", 32'(bus_busy), 32'h1);
      bus_stop();
      chk("R10 ctrl keeps first", 32'(ctrl_reg), 32'h03);
   endtask

   initial begin
      for (int k = 1; k <= NB; k++) xfer_bytes[8*k-1 -: 8] = bval(k);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_write();
      t_read(4);
      t_read(NB + 2);
      t_restart();
      t_mismatch();
      t_cs_high();
      t_extra_write();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nvec++;
         nbad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule